// File: doc/BRIEF.md
# Chained Multiply-Accumulate Carry Unit

This block computes one row of a multi-word unsigned multiplication. Each element is an unsigned multiply-add of three words, `a * b + c`. The result is twice the word width: the low word is written to a per-element low result, and the high word is available as a wide carry. After a start request, a sequencer walks the elements one per clock, lowest index first. In chained mode, each element's high word becomes the addend of the next element. The caller supplies only the first addend, and only the last high word leaves the block as `carry_out`. This lets a multi-word multiplicand be multiplied by a single word in one pass.

Each element can take its multiplier from its own slot or from one shared scalar. A second mode stops the chaining. In that mode every element adds the same scalar addend, and each high word goes into its own slot of a separate high-result vector. All operands, the length and both mode bits are captured on the accepted start. The `done` pulse marks the cycle in which every result is valid.

Top module: `mac_chain_unit`

## Requirements
- R1: For each processed element i, the pair {high word, `lo_vec` slot i} equals the unsigned value a[i] * m + c, where m is the multiplier and c is the addend used for that element. No overflow or carry flag exists, because this value always fits in two words.
- R2: With `hi_separate` = 0 (chained), element 0 adds `carry_in`, and each element i > 0 adds the high word of element i-1. `carry_out` is the high word of the last element.
- R3: With `hi_separate` = 1, every element adds `carry_in`. Slot i of `hi_vec` receives the high word of element i, and `carry_out` is the high word of the last element.
- R4: With `hi_separate` = 0, every slot of `hi_vec` keeps the value it held before the run.
- R5: With `mult_shared` = 1, every element multiplies by `mult_scalar`. With `mult_shared` = 0, element i multiplies by slot i of `b_vec`. Slot i of each packed vector occupies bits [i*DATA_W +: DATA_W].
- R6: If `start` is sampled high while idle at clock edge k, then `done` is high for exactly one cycle, directly after edge k+VL.
- R7: Slots at index VL and above in `lo_vec` and `hi_vec` keep their previous values.
- R8: Operands, modes and length are captured at the accepted start. A `start` request, or any change to the inputs, that occurs while a run is in progress has no effect on that run's results.
- R9: A requested length of 0 runs one element. A requested length above MAX_VL runs MAX_VL elements.
- R10: After reset, `done` is low and `lo_vec`, `hi_vec` and `carry_out` are all zero.
- R11: With VL = 1, the block performs a single multiply-add: `lo_vec` slot 0 and `carry_out` hold the low and high words of a[0] * m + `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a run; accepted only when idle |
| vl | input | $clog2(MAX_VL+1) | Requested element count |
| mult_shared | input | 1 | 1: all elements use `mult_scalar` as multiplier |
| hi_separate | input | 1 | 1: high words go to `hi_vec`, no chaining |
| carry_in | input | DATA_W | Initial (or, in separate mode, every) addend |
| mult_scalar | input | DATA_W | Shared multiplier |
| a_vec | input | MAX_VL*DATA_W | Packed multiplicands |
| b_vec | input | MAX_VL*DATA_W | Packed per-element multipliers |
| lo_vec | output | MAX_VL*DATA_W | Packed low result words |
| hi_vec | output | MAX_VL*DATA_W | Packed high result words (separate mode) |
| carry_out | output | DATA_W | High word of the last element processed |
| done | output | 1 | One-cycle pulse when all results are valid |

## Verification
The bench builds the unit with DATA_W = 16 and MAX_VL = 4. With 16-bit words, every product fits in the bench's native 64-bit integer arithmetic. It also makes a grid sweep of single-element multiply-adds across the full operand range practical, including the all-ones corner with the maximal addend. The 3-bit length input covers every legal length, plus zero and values above MAX_VL. Every combination of chaining mode and multiplier source is run against a bench model that keeps its own copy of the result slots, so preserved and untouched slots are compared as well.

// File: rtl/mac_chain_pkg.sv
package mac_chain_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic {
    ADD_CHAINED = 1'b0,
    ADD_SCALAR  = 1'b1
  } addend_src_e;

endpackage

// File: rtl/mac_chain_core.sv
module mac_chain_core #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] mcand,
  input  logic [DATA_W-1:0] mplier,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] prod_lo,
  output logic [DATA_W-1:0] prod_hi
);

  localparam int WIDE_W = 2 * DATA_W;

  // Widening unsigned multiply-add; the result never exceeds WIDE_W bits.
  function automatic logic [WIDE_W-1:0] mul_add_wide(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic [DATA_W-1:0] z
  );
    logic [WIDE_W-1:0] xw, yw, zw;
    xw = {{DATA_W{1'b0}}, x};
    yw = {{DATA_W{1'b0}}, y};
    zw = {{DATA_W{1'b0}}, z};
    return (xw * yw) + zw;
  endfunction

  logic [WIDE_W-1:0] wide_res;

  always_comb begin
    wide_res = mul_add_wide(mcand, mplier, addend);
    prod_lo  = wide_res[DATA_W-1:0];
    prod_hi  = wide_res[WIDE_W-1:DATA_W];
  end

endmodule

// File: rtl/mac_chain_seq.sv
module mac_chain_seq
  import mac_chain_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vl_req,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             elem_we,
  output logic             elem_last,
  output logic             done
);

  localparam logic [VL_W-1:0] VL_MAX = VL_W'(MAX_VL);
  localparam logic [VL_W-1:0] VL_ONE = VL_W'(1);

  seq_state_e      state_q;
  logic [VL_W-1:0] vl_q;
  logic [VL_W-1:0] vl_eff;
  logic [VL_W-1:0] idx_ext;

  // Length clamp into the legal range 1..MAX_VL.
  always_comb begin
    if (vl_req == '0)          vl_eff = VL_ONE;
    else if (vl_req > VL_MAX)  vl_eff = VL_MAX;
    else                       vl_eff = vl_req;
  end

  assign busy      = (state_q == SEQ_RUN);
  assign accept    = start && !busy;
  assign elem_we   = busy;
  assign idx_ext   = VL_W'(idx);
  assign elem_last = busy && ((idx_ext + VL_ONE) == vl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      vl_q    <= VL_ONE;
      idx     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= SEQ_RUN;
        vl_q    <= vl_eff;
        idx     <= '0;
      end else if (busy) begin
        if (elem_last) begin
          state_q <= SEQ_IDLE;
          done    <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the captured length stays in 1..MAX_VL during a run
  assert_len_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vl_q >= VL_ONE && vl_q <= VL_MAX));

  // R7: the element index never reaches the captured length
  assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_ext < vl_q));

  // R8: a run advances one element per cycle, untouched by start
  assert_run_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_last) |=> (busy && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/mac_chain_bank.sv
module mac_chain_bank #(
  parameter int DATA_W = 64,
  parameter int MAX_VL = 8,
  parameter int IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_hi,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          lo_in,
  input  logic [DATA_W-1:0]          hi_in,
  output logic [MAX_VL*DATA_W-1:0]   lo_flat,
  output logic [MAX_VL*DATA_W-1:0]   hi_flat
);

  for (genvar g = 0; g < MAX_VL; g++) begin : g_slot
    logic slot_sel;
    assign slot_sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_flat[g*DATA_W +: DATA_W] <= '0;
        hi_flat[g*DATA_W +: DATA_W] <= '0;
      end else if (slot_sel) begin
        lo_flat[g*DATA_W +: DATA_W] <= lo_in;
        if (wr_hi) hi_flat[g*DATA_W +: DATA_W] <= hi_in;
      end
    end
  end

  // R4: chained writes leave the high-word vector untouched
  assert_hi_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> $stable(hi_flat));

endmodule

// File: rtl/mac_chain_unit.sv
module mac_chain_unit
  import mac_chain_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int MAX_VL = 8,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int VEC_W  = MAX_VL * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic              mult_shared,
  input  logic              hi_separate,
  input  logic [DATA_W-1:0] carry_in,
  input  logic [DATA_W-1:0] mult_scalar,
  input  logic [VEC_W-1:0]  a_vec,
  input  logic [VEC_W-1:0]  b_vec,
  output logic [VEC_W-1:0]  lo_vec,
  output logic [VEC_W-1:0]  hi_vec,
  output logic [DATA_W-1:0] carry_out,
  output logic              done
);

  // Named internal events
  logic              accept;
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic              elem_we;
  logic              elem_last;

  // Captured operands
  logic [DATA_W-1:0] a_q [MAX_VL];
  logic [DATA_W-1:0] b_q [MAX_VL];
  logic [DATA_W-1:0] mscalar_q;
  logic [DATA_W-1:0] cin_q;
  logic              shared_q;
  addend_src_e       add_src_q;
  logic [DATA_W-1:0] chain_q;

  // Datapath wires
  logic [DATA_W-1:0] mcand;
  logic [DATA_W-1:0] mplier;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] prod_lo;
  logic [DATA_W-1:0] prod_hi;

  mac_chain_seq #(
    .MAX_VL (MAX_VL),
    .VL_W   (VL_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl_req    (vl),
    .accept    (accept),
    .busy      (busy),
    .idx       (idx),
    .elem_we   (elem_we),
    .elem_last (elem_last),
    .done      (done)
  );

  for (genvar g = 0; g < MAX_VL; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[g] <= '0;
        b_q[g] <= '0;
      end else if (accept) begin
        a_q[g] <= a_vec[g*DATA_W +: DATA_W];
        b_q[g] <= b_vec[g*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mscalar_q <= '0;
      cin_q     <= '0;
      shared_q  <= 1'b0;
      add_src_q <= ADD_CHAINED;
    end else if (accept) begin
      mscalar_q <= mult_scalar;
      cin_q     <= carry_in;
      shared_q  <= mult_shared;
      add_src_q <= hi_separate ? ADD_SCALAR : ADD_CHAINED;
    end
  end

  // Wide carry register: seeded at start, then fed by each high word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (accept) begin
      chain_q <= carry_in;
    end else if (elem_we && add_src_q == ADD_CHAINED) begin
      chain_q <= prod_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       carry_out <= '0;
    else if (elem_we) carry_out <= prod_hi;
  end

  assign mcand  = a_q[idx];
  assign mplier = shared_q ? mscalar_q : b_q[idx];
  assign addend = (add_src_q == ADD_SCALAR) ? cin_q : chain_q;

  mac_chain_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .mcand   (mcand),
    .mplier  (mplier),
    .addend  (addend),
    .prod_lo (prod_lo),
    .prod_hi (prod_hi)
  );

  mac_chain_bank #(
    .DATA_W (DATA_W),
    .MAX_VL (MAX_VL),
    .IDX_W  (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (elem_we),
    .wr_hi   (add_src_q == ADD_SCALAR),
    .wr_idx  (idx),
    .lo_in   (prod_lo),
    .hi_in   (prod_hi),
    .lo_flat (lo_vec),
    .hi_flat (hi_vec)
  );

  // R2: in chained mode the next element adds the previous high word
  assert_chain_feed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_we && add_src_q == ADD_CHAINED && !elem_last) |=> (addend == $past(prod_hi)));

  // R1: a zero product with a zero addend yields an all-zero result
  assert_zero_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_we && addend == '0 && (mcand == '0 || mplier == '0)) |-> (prod_lo == '0 && prod_hi == '0));

  // R2: the exported carry is the last element's high word once done
  assert_carry_export_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_we && elem_last) |=> (done && carry_out == $past(prod_hi)));

  // R8: operands captured at start hold for the whole run
  assert_operands_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_last) |=> ($stable(cin_q) && $stable(mscalar_q) && $stable(shared_q)));

endmodule

// File: tb/mac_chain_unit_test.sv
module mac_chain_unit_test;

  localparam int W          = 16;
  localparam int NV         = 4;
  localparam int VW         = $clog2(NV + 1);
  localparam int CLK_PERIOD = 10;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [VW-1:0]     vl;
  logic              mult_shared;
  logic              hi_separate;
  logic [W-1:0]      carry_in;
  logic [W-1:0]      mult_scalar;
  logic [NV*W-1:0]   a_vec;
  logic [NV*W-1:0]   b_vec;
  logic [NV*W-1:0]   lo_vec;
  logic [NV*W-1:0]   hi_vec;
  logic [W-1:0]      carry_out;
  logic              done;

  mac_chain_unit #(.DATA_W(W), .MAX_VL(NV)) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .vl (vl),
    .mult_shared (mult_shared), .hi_separate (hi_separate),
    .carry_in (carry_in), .mult_scalar (mult_scalar),
    .a_vec (a_vec), .b_vec (b_vec), .lo_vec (lo_vec), .hi_vec (hi_vec),
    .carry_out (carry_out), .done (done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] in_a [NV];
  logic [W-1:0] in_b [NV];
  logic [W-1:0] lo_m [NV];
  logic [W-1:0] hi_m [NV];
  logic [W-1:0] cout_m;
  int unsigned  seed = 32'h1234_5678;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  // Runs one request and compares every slot against the bench's model.
  task automatic run_op(input int vreq, input bit sep, input bit shr,
                        input logic [W-1:0] msc, input logic [W-1:0] cin,
                        input bit disturb);
    int ve;
    int n;
    longint p;
    logic [W-1:0] chain;
    logic [W-1:0] m;
    logic [W-1:0] c;
    ve = (vreq == 0) ? 1 : ((vreq > NV) ? NV : vreq);   // R9
    chain = cin;
    for (int i = 0; i < ve; i++) begin
      m = shr ? msc : in_b[i];                          // R5
      c = sep ? cin : chain;                            // R2 / R3
      p = longint'(in_a[i]) * longint'(m) + longint'(c); // R1
      lo_m[i] = p[W-1:0];
      if (sep) hi_m[i] = p[2*W-1:W];
      chain = p[2*W-1:W];
    end
    cout_m = chain;

    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      a_vec[i*W +: W] = in_a[i];
      b_vec[i*W +: W] = in_b[i];
    end
    vl = VW'(vreq);
    hi_separate = sep;
    mult_shared = shr;
    mult_scalar = msc;
    carry_in = cin;
    start = 1;
    @(negedge clk);
    if (disturb) begin
      // R8: second request and new operands while busy
      for (int i = 0; i < NV; i++) a_vec[i*W +: W] = ~in_a[i];
      carry_in = ~cin;
      mult_scalar = ~msc;
      hi_separate = ~sep;
    end else begin
      start = 0;
    end
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      start = 0;
      n++;
    end
    check(n == ve, "R6 latency", n, ve);
    for (int i = 0; i < NV; i++) begin
      check(lo_vec[i*W +: W] == lo_m[i], "R1/R7 lo slot", lo_vec[i*W +: W], lo_m[i]);
      check(hi_vec[i*W +: W] == hi_m[i], "R3/R4 hi slot", hi_vec[i*W +: W], hi_m[i]);
    end
    check(carry_out == cout_m, "R2 carry_out", carry_out, cout_m);
    @(negedge clk);
    check(done == 1'b0, "R6 single pulse", done, 0);
  endtask

  initial begin
    logic [W-1:0] grid [18];
    rst_n = 0; start = 0; vl = '0; mult_shared = 0; hi_separate = 0;
    carry_in = '0; mult_scalar = '0; a_vec = '0; b_vec = '0;
    for (int i = 0; i < NV; i++) begin
      lo_m[i] = '0; hi_m[i] = '0; in_a[i] = '0; in_b[i] = '0;
    end
    cout_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check(done == 1'b0, "R10 done", done, 0);
    check(lo_vec == '0, "R10 lo_vec", lo_vec, 0);
    check(hi_vec == '0, "R10 hi_vec", hi_vec, 0);
    check(carry_out == '0, "R10 carry_out", carry_out, 0);

    // R11 / R1: grid sweep of single multiply-adds, corners included
    for (int i = 0; i < 16; i++) grid[i] = W'(i * 4369 + (i % 3));
    grid[16] = 16'hFFFF;
    grid[17] = 16'h0001;
    for (int x = 0; x < 18; x++) begin
      for (int y = 0; y < 18; y++) begin
        in_a[0] = grid[x];
        in_b[0] = grid[y];
        run_op(1, 0, (y % 2) == 1, grid[y], (x + y) % 2 == 0 ? 16'h0000 : 16'hFFFF, 0);
      end
    end

    // R2 R3 R4 R5 R7 R9: every length request, both modes, both multiplier sources
    for (int pat = 0; pat < 3; pat++) begin
      for (int v = 0; v < (1 << VW); v++) begin
        for (int md = 0; md < 4; md++) begin
          for (int i = 0; i < NV; i++) begin
            in_a[i] = (pat == 0) ? 16'hFFFF : rnd();
            in_b[i] = (pat == 0) ? 16'hFFFF : ((pat == 1) ? rnd() : W'(i + 1));
          end
          run_op(v, md[0], md[1], (pat == 0) ? 16'hFFFF : rnd(),
                 (pat == 0) ? 16'hFFFF : rnd(), 0);
        end
      end
    end

    // R8: start and operand changes during a run are ignored
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NV; i++) begin
        in_a[i] = rnd();
        in_b[i] = rnd();
      end
      run_op(NV, k[0], k[1], rnd(), rnd(), 1);
    end

    finish_run();
  end

endmodule